// File: doc/BRIEF.md
# Double-Data-Rate Write Capture

This block receives write data from a double-data-rate bus. Each byte lane carries its own bidirectional data strobe. While the write window is open, the lane samples its data byte and its mask bit on both edges of its strobe. The beat taken on the rising edge and the beat taken on the falling edge form one pair, and that pair is held in a two-slot buffer in the strobe domain.

Once every lane holds a complete pair, the core clock domain reads the pairs and presents one word that is twice the bus width. The rising-edge beat fills the low half of the word and the falling-edge beat fills the high half, so each core clock moves two bus-width items. A byte-enable vector and a one-cycle valid go with the word.

The strobe is expected to be centred in the data eye, so the data is sampled directly on the strobe edges. The delay-line trimming that centres the strobe is handled outside this block.

Top module: `ddr_wr_capture`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `wvalid` is low in the following cycle. No pair written before the release of `rst` is ever presented.
- R2: In the presented word, bits `[8*l+7:8*l]` hold lane l's byte from the rising strobe edge. Bits `[W+8*l+7:W+8*l]` hold lane l's byte from the falling strobe edge, where W = 8*LANES.
- R3: `wben` bit l is the inverse of lane l's mask bit sampled on the rising edge. `wben` bit LANES+l is the inverse of lane l's mask bit sampled on the falling edge. A mask bit sampled high therefore gives an enable of 0, meaning the byte must not be written.
- R4: Lane l samples `dq[8*l+7:8*l]` and `dm[l]` only on edges of `dqs[l]`. A lane whose strobe is skewed against the other lanes still captures its own data.
- R5: `wvalid` is high for exactly one `clk` cycle per captured pair. That cycle begins at the first rising `clk` edge after the falling strobe edge that completed the pair in every lane.
- R6: Strobe edges that occur while `wr_win` is low store nothing and produce no `wvalid`.
- R7: A pair is captured in every `clk` cycle of a continuous burst. The pairs come out on consecutive cycles in the order they were captured, and a lane never holds more than two unread pairs.
- R8: A falling strobe edge stores a pair only if a rising edge inside the window came before it. If the window opens between the two edges, or closes between them, nothing is stored and the next complete pair comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset. Also sampled on strobe edges |
| wr_win | input | 1 | Write window; strobe edges count only while it is high |
| dq | input | 8*LANES | Write data bus |
| dm | input | LANES | Per-lane write mask, active high |
| dqs | input | LANES | Per-lane data strobe |
| wdata | output | 16*LANES | Assembled word: rising beat low, falling beat high |
| wben | output | 2*LANES | Byte enables, inverse of the sampled masks |
| wvalid | output | 1 | One-cycle valid for `wdata`/`wben` |

## Verification
The hardest cases to reach from the ports are a window that changes state between the rising and falling edges of one strobe pulse, and a lane strobe that lags its neighbour. In those cases a lane may capture a stale or half pair without any visible sign. The stimulus covers both. Directed bursts open the window in the middle of a pulse and close it in the middle of a pulse. The second lane's strobe and data are shifted late by up to 1.5 ns, with the first lane's data already changed when the second lane samples. Random bursts mix these modes with bursts outside the window, idle gaps and back-to-back runs.

// File: rtl/ddr_wcap_pkg.sv
`timescale 1ns/1ps
package ddr_wcap_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2;   // two slots plus wrap bit

    typedef struct packed {
        logic [BYTE_W-1:0] fall_d;
        logic [BYTE_W-1:0] rise_d;
        logic              fall_m;
        logic              rise_m;
    } lane_pair_t;

    function automatic logic [PTR_W-1:0] ptr_fill(input logic [PTR_W-1:0] wp,
                                                  input logic [PTR_W-1:0] rp);
        return wp - rp;
    endfunction
endpackage

// File: rtl/wcap_lane.sv
`timescale 1ns/1ps
module wcap_lane
    import ddr_wcap_pkg::*;
(
    input  logic                     dqs,
    input  logic                     rst,
    input  logic                     win,
    input  logic [BYTE_W-1:0]        dq,
    input  logic                     dm,
    output lane_pair_t [1:0]         slots,
    output logic [PTR_W-1:0]         wptr
);
    logic              rise_tog;
    logic              fall_tog;
    logic [BYTE_W-1:0] rise_d;
    logic              rise_m;
    logic              armed;

    assign armed = rise_tog != fall_tog;

    // Rising edge: hold the first beat and arm, or disarm outside the window
    always_ff @(posedge dqs) begin
        if (rst) begin
            rise_tog <= 1'b0;
            rise_d   <= '0;
            rise_m   <= 1'b0;
        end else if (win) begin
            rise_tog <= ~fall_tog;
            rise_d   <= dq;
            rise_m   <= dm;
        end else begin
            rise_tog <= fall_tog;
        end
    end

    // Falling edge: complete the pair only when armed and inside the window
    always_ff @(negedge dqs) begin
        if (rst) begin
            fall_tog <= 1'b0;
            wptr     <= '0;
            slots    <= '0;
        end else if (win && armed) begin
            slots[wptr[0]] <= '{fall_d: dq, rise_d: rise_d, fall_m: dm, rise_m: rise_m};
            wptr           <= wptr + 1'b1;
            fall_tog       <= rise_tog;
        end
    end
endmodule

// File: rtl/wcap_ptr_sync.sv
`timescale 1ns/1ps
module wcap_ptr_sync
    import ddr_wcap_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0][PTR_W-1:0] wptr_in,
    output logic [LANES-1:0][PTR_W-1:0] wptr_ck
);
    always_ff @(posedge clk) begin
        if (rst) wptr_ck <= '0;
        else     wptr_ck <= wptr_in;
    end
endmodule

// File: rtl/wcap_assemble.sv
`timescale 1ns/1ps
module wcap_assemble
    import ddr_wcap_pkg::*;
#(
    parameter int LANES = 2,
    localparam int W    = LANES * BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0][PTR_W-1:0] wptr_ck,
    input  lane_pair_t [LANES-1:0][1:0] slots,
    output logic [2*W-1:0]              wdata,
    output logic [2*LANES-1:0]          wben,
    output logic                        wvalid,
    output logic [PTR_W-1:0]            rptr
);
    logic [LANES-1:0] lane_ready;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_pair_t cur;
        assign cur                          = slots[l][rptr[0]];
        assign lane_ready[l]                = ptr_fill(wptr_ck[l], rptr) != '0;
        assign wdata[l*BYTE_W +: BYTE_W]     = cur.rise_d;
        assign wdata[W + l*BYTE_W +: BYTE_W] = cur.fall_d;
        assign wben[l]                      = ~cur.rise_m;
        assign wben[LANES + l]              = ~cur.fall_m;
    end

    assign wvalid = &lane_ready;

    always_ff @(posedge clk) begin
        if (rst)         rptr <= '0;
        else if (wvalid) rptr <= rptr + 1'b1;
    end
endmodule

// File: rtl/ddr_wr_capture.sv
`timescale 1ns/1ps
module ddr_wr_capture
    import ddr_wcap_pkg::*;
#(
    parameter int LANES = 2,
    localparam int W    = LANES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_win,
    input  logic [W-1:0]         dq,
    input  logic [LANES-1:0]     dm,
    input  logic [LANES-1:0]     dqs,
    output logic [2*W-1:0]       wdata,
    output logic [2*LANES-1:0]   wben,
    output logic                 wvalid
);
    lane_pair_t [LANES-1:0][1:0]  slots;
    logic [LANES-1:0][PTR_W-1:0]  wptr_dqs;
    logic [LANES-1:0][PTR_W-1:0]  wptr_ck;
    logic [PTR_W-1:0]             rptr;

    for (genvar l = 0; l < LANES; l++) begin : g_cap
        wcap_lane u_lane (
            .dqs   (dqs[l]),
            .rst   (rst),
            .win   (wr_win),
            .dq    (dq[l*BYTE_W +: BYTE_W]),
            .dm    (dm[l]),
            .slots (slots[l]),
            .wptr  (wptr_dqs[l])
        );
    end

    wcap_ptr_sync #(.LANES(LANES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .wptr_in (wptr_dqs),
        .wptr_ck (wptr_ck)
    );

    wcap_assemble #(.LANES(LANES)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .wptr_ck (wptr_ck),
        .slots   (slots),
        .wdata   (wdata),
        .wben    (wben),
        .wvalid  (wvalid),
        .rptr    (rptr)
    );
endmodule

// File: rtl/ddr_wr_capture_chk.sv
`timescale 1ns/1ps
module ddr_wr_capture_chk
    import ddr_wcap_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_win,
    input logic                        wvalid,
    input logic [LANES-1:0][PTR_W-1:0] wptr_ck,
    input logic [PTR_W-1:0]            rptr
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !wvalid); // R1

    AST_VALID_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> $past(wr_win)); // R6

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            ptr_fill(wptr_ck[l], rptr) <= 2'd2); // R7

        AST_ONE_PAIR_PER_CK: assert property (@(posedge clk) disable iff (rst)
            (PTR_W'(wptr_ck[l] - $past(wptr_ck[l])) <= 2'd1)); // R7
    end
endmodule

bind ddr_wr_capture ddr_wr_capture_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_win  (wr_win),
    .wvalid  (wvalid),
    .wptr_ck (wptr_ck),
    .rptr    (rptr)
);

// File: tb/sim_ddr_wr_capture.sv
`timescale 1ns/1ps
module sim_ddr_wr_capture;
    localparam int L = 2;
    localparam int W = 8 * L;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_win = 1'b0;
    logic [W-1:0]   dq = '0;
    logic [L-1:0]   dm = '0;
    logic [L-1:0]   dqs = '0;
    logic [2*W-1:0] wdata;
    logic [2*L-1:0] wben;
    logic           wvalid;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    running = 0;
    string tag = "R2";

    typedef struct packed {
        int               due;
        logic [2*W-1:0]   d;
        logic [2*L-1:0]   b;
    } exp_t;
    exp_t q[$];

    ddr_wr_capture #(.LANES(L)) u0 (
        .clk(clk), .rst(rst), .wr_win(wr_win), .dq(dq), .dm(dm), .dqs(dqs),
        .wdata(wdata), .wben(wben), .wvalid(wvalid)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2*L-1:0] exp_ben(input logic [2*L-1:0] m);
        return ~m;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Lane driver: rising beat, strobe up, falling beat, strobe down
    task automatic drive_lane(input int l, input int sk, input logic [7:0] r,
                              input logic [7:0] f, input logic rm, input logic fm);
        #(sk * 0.1);
        dq[l*8 +: 8] = r; dm[l] = rm;
        #1.5 dqs[l] = 1'b1;
        #2.5 dq[l*8 +: 8] = f; dm[l] = fm;
        #2.5 dqs[l] = 1'b0;
    endtask

    // mode 0 in window, 1 outside window, 2 window opens mid-pulse, 3 closes mid-pulse
    task automatic burst(input logic [2*W-1:0] d, input logic [2*L-1:0] m,
                         input int mode, input int skew);
        if (mode == 0) q.push_back('{due: cyc + 1, d: d, b: exp_ben(m)});
        fork
            begin
                case (mode)
                    0: wr_win = 1'b1;
                    1: wr_win = 1'b0;
                    2: begin wr_win = 1'b0; #4 wr_win = 1'b1; end
                    default: begin wr_win = 1'b1; #4 wr_win = 1'b0; end
                endcase
            end
            drive_lane(0, 0, d[7:0], d[W+7:W], m[0], m[L]);
            drive_lane(1, skew, d[15:8], d[W+15:W+8], m[1], m[L+1]);
        join
        @(posedge clk); #1;
    endtask

    task automatic idle();
        wr_win = 1'b0;
        @(posedge clk); #1;
    endtask

    always @(negedge clk) begin
        if (running) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                chk({"R5 ", tag}, 64'(wvalid), 64'd1);
                chk(tag, 64'(wdata), 64'(q[0].d));
                chk("R3", 64'(wben), 64'(q[0].b));
                void'(q.pop_front());
            end else begin
                chk({"R5 ", tag}, 64'(wvalid), 64'd0);
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        @(posedge clk); #1;
        // reset with strobes toggling, window closed
        for (int i = 0; i < 4; i++) burst(32'hDEAD_BEEF, 4'h0, 1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 64'(wvalid), 64'd0);
        @(posedge clk); #1;
        running = 1;

        // R2/R3 directed patterns
        tag = "R2";
        burst(32'hA1B2_C3D4, 4'b0000, 0, 0);
        idle();
        burst(32'h0102_0304, 4'b1010, 0, 0);
        burst(32'hFFEE_DDCC, 4'b0101, 0, 0);
        idle(); idle();
        // R4: lane 1 strobe late, lane 0 data already changed when lane 1 samples
        tag = "R4";
        burst(32'h5A5A_A5A5, 4'b0110, 0, 15);
        burst(32'h1234_5678, 4'b1001, 0, 10);
        idle();
        // R6: strobes outside the window
        tag = "R6";
        burst(32'hBAD0_BAD0, 4'b0000, 1, 0);
        burst(32'hBAD1_BAD1, 4'b1111, 1, 0);
        idle();
        burst(32'h6677_8899, 4'b0011, 0, 0);
        idle();
        // R8: window opening or closing between edges
        tag = "R8";
        burst(32'hC0DE_C0DE, 4'b0000, 2, 0);
        burst(32'h1111_2222, 4'b1100, 0, 0);
        burst(32'hC1DE_C1DE, 4'b0000, 3, 0);
        idle();
        burst(32'h3333_4444, 4'b0001, 0, 0);
        idle();
        // R7: continuous burst
        tag = "R7";
        for (int i = 0; i < 8; i++) burst(32'h0F00_0000 + 32'(i * 32'h0101_0101), 4'(i), 0, 0);
        idle(); idle();

        // random mix
        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 6)       burst($urandom, 4'($urandom), 0, int'($urandom_range(0, 15)));
            else if (k == 6) burst($urandom, 4'($urandom), 1, 0);
            else if (k == 7) burst($urandom, 4'($urandom), int'($urandom_range(2, 3)), 0);
            else             idle();
        end
        idle(); idle(); idle();
        running = 0;
        chk("R5 drain", 64'(q.size()), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule